// File: doc/BRIEF.md
# Pass/Fail Linearity BIST Sequencer

This block drives a go/no-go static linearity test of an on-chip data converter. When a tester raises a one-cycle enable, the sequencer asks an external transition-measurement engine for the lowest and the highest transition levels, and keeps them as the two ends of the endpoint-fit line. It then asks for further transition levels one code at a time. For each one it evaluates the integral nonlinearity against the fit and stops as soon as any code falls outside the allowed error. If no code does, the part passes.

The INL test uses only integer multiply, subtract and compare, so no divider is needed. The order of codes is chosen by a mode input. The plain order is an ascending sweep. The structure-aware order visits a window of codes around the half-scale boundary first, then around the quarter-scale boundaries, and so on down to the lowest bit. This finds a bad part early when its worst errors sit at major carries. The measurement engine is attached through a request/acknowledge pair.

Top module: `lin_bist_seq`

## Requirements
- R1: A start pulse is accepted only while the block is not busy. Busy rises in the following cycle. The order mode, window and error limit are sampled at acceptance, and a start pulse seen while busy has no effect.
- R2: The first two measurement requests of every run carry code 1 and then code N−1. Their results are kept as the fit endpoints T1 and Thi.
- R3: A request holds its code stable until the cycle in which acknowledge is high. The measured value is taken in that same cycle.
- R4: Code k violates when |(Tk−T1)(N−2) − (k−1)(Thi−T1)|·16 > spec·(Thi−T1). Here spec is an unsigned error limit in sixteenths of an LSB (4 fraction bits). Equality passes.
- R5: The first violating code ends the run. The block raises done with pass low and reports that code as the failing code, and issues no further requests.
- R6: If every listed code is within the limit, the block ends with done high, pass high and failing code 0.
- R7: With mode 0, codes 2, 3, … N−2 are measured in ascending order.
- R8: With mode 1, the block walks bit levels b from n−1 down to 0. Within a level it takes centres (2m+1)·2^b in ascending m. Around each centre it takes offsets −W … +W in ascending order, where W is the window input.
- R9: In mode 1, codes outside 2…N−2 are skipped and no code is requested twice. A full run therefore covers every code from 2 to N−2 exactly once.
- R10: If Thi ≤ T1, the run fails at once with failing code N−1, after only the two endpoint measurements.
- R11: Done, pass and the failing code hold their values until the next accepted start, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle test enable from the tester |
| mode_i | input | 1 | Code order: 0 ascending sweep, 1 boundary-priority |
| win_i | input | WIN_W | Half-width W of the window around each boundary |
| spec_i | input | SPEC_W | INL limit in sixteenths of an LSB |
| meas_req_o | output | 1 | Measurement request to the engine |
| meas_code_o | output | CODE_W | Code whose transition level is requested |
| meas_ack_i | input | 1 | Engine acknowledge; value valid in this cycle |
| meas_val_i | input | MEAS_W | Measured transition level |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished, result valid |
| pass_o | output | 1 | All tested codes within the limit |
| fail_code_o | output | CODE_W | First code found out of bound, 0 on pass |

## Verification
The two events that can land together are the end of the code list and a violation on the very code that ends it. In that case the fail must win over the pass that list exhaustion would otherwise give. The bench provokes this by first working out, in boundary-priority order, the last code the list will reach. It then plants an error just over the limit on exactly that code, and expects a fail naming it after the full request count. A second coincidence, a start pulse arriving mid-run while the error limit input changes, is judged by the result and request count staying those of the original run.

// File: rtl/lin_bist_pkg.sv
package lin_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_SCAN,
        ST_MEAS,
        ST_EVAL,
        ST_DONE
    } bist_st_e;

    typedef enum logic {
        ORD_COUNT = 1'b0,
        ORD_PRIO  = 1'b1
    } ord_e;

endpackage

// File: rtl/lin_code_seq.sv
module lin_code_seq
    import lin_bist_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int WIN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              mode_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic              take_i,
    output logic              valid_o,
    output logic              exh_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int N  = 1 << CODE_W;
    localparam int CW = CODE_W + WIN_W + 2;

    typedef struct packed {
        ord_e                mode;
        logic [WIN_W-1:0]    win;
        logic [CODE_W-1:0]   lvl;
        logic [CODE_W-1:0]   idx;
        logic signed [WIN_W:0] off;
        logic                exh;
        logic [N-1:0]        tested;
    } gen_t;

    gen_t q, d;

    logic signed [WIN_W:0]  win_s;
    logic [CW-1:0]          cen;
    logic signed [CW-1:0]   cand;
    logic signed [CW-1:0]   lo_b;
    logic signed [CW-1:0]   hi_b;
    logic                   in_rng;
    logic                   fresh;
    logic [CODE_W-1:0]      idx_lim;

    assign win_s = $signed({1'b0, q.win});
    assign lo_b  = $signed(CW'(2));
    assign hi_b  = $signed(CW'(N - 2));

    always_comb begin
        cen     = CW'({q.idx, 1'b1}) << q.lvl;
        idx_lim = CODE_W'(((N / 2) >> q.lvl) - 1);
        if (q.mode == ORD_PRIO)
            cand = $signed(cen) + $signed({{(CW-WIN_W-1){q.off[WIN_W]}}, q.off});
        else
            cand = $signed(CW'(q.idx));
        in_rng  = (cand >= lo_b) && (cand <= hi_b);
        fresh   = !q.tested[cand[CODE_W-1:0]];
        valid_o = !q.exh && in_rng && fresh;
        exh_o   = q.exh;
        code_o  = cand[CODE_W-1:0];
    end

    always_comb begin
        d = q;
        if (clr_i) begin
            d.mode   = ord_e'(mode_i);
            d.win    = win_i;
            d.lvl    = CODE_W'(CODE_W - 1);
            d.idx    = (ord_e'(mode_i) == ORD_PRIO) ? '0 : CODE_W'(2);
            d.off    = -$signed({1'b0, win_i});
            d.exh    = 1'b0;
            d.tested = '0;
        end else if (!q.exh && (!valid_o || take_i)) begin
            if (take_i)
                d.tested[cand[CODE_W-1:0]] = 1'b1;
            if (q.mode == ORD_COUNT) begin
                if (q.idx >= CODE_W'(N - 2))
                    d.exh = 1'b1;
                else
                    d.idx = q.idx + 1'b1;
            end else if (q.off < win_s) begin
                d.off = q.off + 1'b1;
            end else begin
                d.off = -win_s;
                if (q.idx >= idx_lim) begin
                    d.idx = '0;
                    if (q.lvl == '0)
                        d.exh = 1'b1;
                    else
                        d.lvl = q.lvl - 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.exh    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_GEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (code_o >= CODE_W'(2)) && (code_o <= CODE_W'(N - 2))); // R9
    AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> valid_o); // R9
    AST_TAKEN_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !clr_i |=> !(valid_o && code_o == $past(code_o))); // R9

endmodule

// File: rtl/lin_inl_chk.sv
module lin_inl_chk #(
    parameter int CODE_W = 5,
    parameter int MEAS_W = 16,
    parameter int SPEC_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic [MEAS_W-1:0] t_lo_i,
    input  logic [MEAS_W-1:0] t_hi_i,
    input  logic [MEAS_W-1:0] t_k_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [SPEC_W-1:0] spec_i,
    output logic              viol_o
);
    localparam int N  = 1 << CODE_W;
    localparam int PW = MEAS_W + CODE_W + SPEC_W + FRAC_W + 4;

    logic signed [PW-1:0] lo_s, hi_s, k_s, nm2, km1;
    logic signed [PW-1:0] dk, span, lhs, mag, lhs_sc, rhs;

    always_comb begin
        lo_s   = $signed(PW'(t_lo_i));
        hi_s   = $signed(PW'(t_hi_i));
        k_s    = $signed(PW'(t_k_i));
        nm2    = $signed(PW'(N - 2));
        km1    = $signed(PW'(code_i) - PW'(1));
        dk     = k_s - lo_s;
        span   = hi_s - lo_s;
        lhs    = dk * nm2 - km1 * span;
        mag    = lhs[PW-1] ? -lhs : lhs;
        lhs_sc = mag <<< FRAC_W;
        rhs    = $signed(PW'(spec_i)) * span;
        viol_o = lhs_sc > rhs;
    end

endmodule

// File: rtl/lin_bist_seq.sv
module lin_bist_seq
    import lin_bist_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int MEAS_W = 16,
    parameter int SPEC_W = 8,
    parameter int FRAC_W = 4,
    parameter int WIN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic [SPEC_W-1:0] spec_i,
    output logic              meas_req_o,
    output logic [CODE_W-1:0] meas_code_o,
    input  logic              meas_ack_i,
    input  logic [MEAS_W-1:0] meas_val_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [CODE_W-1:0] fail_code_o
);
    localparam int N = 1 << CODE_W;

    typedef struct packed {
        bist_st_e           st;
        logic               req;
        logic [CODE_W-1:0]  code;
        logic [MEAS_W-1:0]  t_lo;
        logic [MEAS_W-1:0]  t_hi;
        logic [MEAS_W-1:0]  t_k;
        logic [SPEC_W-1:0]  spec;
        logic               done;
        logic               pass;
        logic [CODE_W-1:0]  fail_code;
    } seq_t;

    seq_t q, d;

    logic              gen_clr;
    logic              gen_take;
    logic              gen_valid;
    logic              gen_exh;
    logic [CODE_W-1:0] gen_code;
    logic              viol;

    lin_code_seq #(
        .CODE_W (CODE_W),
        .WIN_W  (WIN_W)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (gen_clr),
        .mode_i  (mode_i),
        .win_i   (win_i),
        .take_i  (gen_take),
        .valid_o (gen_valid),
        .exh_o   (gen_exh),
        .code_o  (gen_code)
    );

    lin_inl_chk #(
        .CODE_W (CODE_W),
        .MEAS_W (MEAS_W),
        .SPEC_W (SPEC_W),
        .FRAC_W (FRAC_W)
    ) u_chk (
        .t_lo_i (q.t_lo),
        .t_hi_i (q.t_hi),
        .t_k_i  (q.t_k),
        .code_i (q.code),
        .spec_i (q.spec),
        .viol_o (viol)
    );

    always_comb begin
        d        = q;
        gen_clr  = 1'b0;
        gen_take = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    d.st        = ST_LO;
                    d.req       = 1'b1;
                    d.code      = CODE_W'(1);
                    d.spec      = spec_i;
                    d.done      = 1'b0;
                    d.pass      = 1'b0;
                    d.fail_code = '0;
                    gen_clr     = 1'b1;
                end
            end
            ST_LO: begin
                if (meas_ack_i) begin
                    d.t_lo = meas_val_i;
                    d.code = CODE_W'(N - 1);
                    d.st   = ST_HI;
                end
            end
            ST_HI: begin
                if (meas_ack_i) begin
                    d.t_hi = meas_val_i;
                    d.req  = 1'b0;
                    if (meas_val_i <= q.t_lo) begin
                        d.st        = ST_DONE;
                        d.done      = 1'b1;
                        d.pass      = 1'b0;
                        d.fail_code = CODE_W'(N - 1);
                    end else begin
                        d.st = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (gen_valid) begin
                    gen_take = 1'b1;
                    d.req    = 1'b1;
                    d.code   = gen_code;
                    d.st     = ST_MEAS;
                end else if (gen_exh) begin
                    d.st   = ST_DONE;
                    d.done = 1'b1;
                    d.pass = 1'b1;
                end
            end
            ST_MEAS: begin
                if (meas_ack_i) begin
                    d.t_k = meas_val_i;
                    d.req = 1'b0;
                    d.st  = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (viol) begin
                    d.st        = ST_DONE;
                    d.done      = 1'b1;
                    d.pass      = 1'b0;
                    d.fail_code = q.code;
                end else begin
                    d.st = ST_SCAN;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign meas_req_o  = q.req;
    assign meas_code_o = q.code;
    assign busy_o      = (q.st != ST_IDLE) && (q.st != ST_DONE);
    assign done_o      = q.done;
    assign pass_o      = q.pass;
    assign fail_code_o = q.fail_code;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o && !meas_ack_i |=> meas_req_o && $stable(meas_code_o)); // R3
    AST_FIRST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> meas_req_o && (meas_code_o == CODE_W'(1))); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !meas_req_o); // R5
    AST_PASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o && (fail_code_o == '0)); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(fail_code_o) && $stable(pass_o)); // R11
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> busy_o || done_o); // R1

endmodule

// File: tb/lin_bist_seq_tb.sv
module lin_bist_seq_tb;
    localparam int CODE_W = 5;
    localparam int MEAS_W = 16;
    localparam int SPEC_W = 8;
    localparam int WIN_W  = 3;
    localparam int N      = 1 << CODE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              mode_i = 1'b0;
    logic [WIN_W-1:0]  win_i = '0;
    logic [SPEC_W-1:0] spec_i = 8'd16;
    logic              meas_req_o;
    logic [CODE_W-1:0] meas_code_o;
    logic              meas_ack_i = 1'b0;
    logic [MEAS_W-1:0] meas_val_i = '0;
    logic              busy_o, done_o, pass_o;
    logic [CODE_W-1:0] fail_code_o;

    always #2 clk = ~clk;

    lin_bist_seq #(
        .CODE_W (CODE_W), .MEAS_W (MEAS_W), .SPEC_W (SPEC_W),
        .FRAC_W (4), .WIN_W (WIN_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
        .win_i (win_i), .spec_i (spec_i), .meas_req_o (meas_req_o),
        .meas_code_o (meas_code_o), .meas_ack_i (meas_ack_i),
        .meas_val_i (meas_val_i), .busy_o (busy_o), .done_o (done_o),
        .pass_o (pass_o), .fail_code_o (fail_code_o)
    );

    int errors = 0;
    int checks = 0;
    int tval [0:N-1];
    int exp_list [0:63];
    int exp_len;
    int exp_pass;
    int exp_fc;
    int req_cnt;
    int mdelay = 0;
    int cur_spec = 16;
    string cur_tag = "R0";

    task automatic check(input string tag, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic set_clean();
        for (int k = 0; k < N; k++) tval[k] = 100 + 16 * k;
    endtask

    // Expected list and result, computed from R2, R4, R7..R10
    task automatic build(input int mode, input int win);
        int seen [0:N-1];
        int c;
        int stop;
        real lsb, inl;
        for (int k = 0; k < N; k++) seen[k] = 0;
        exp_len = 2; exp_list[0] = 1; exp_list[1] = N - 1;
        exp_pass = 1; exp_fc = 0;
        if (tval[N-1] <= tval[1]) begin
            exp_pass = 0; exp_fc = N - 1;
            return;
        end
        lsb = real'(tval[N-1] - tval[1]) / real'(N - 2);
        stop = 0;
        for (int b = CODE_W - 1; b >= 0; b--) begin
            for (int m = 0; m < (N >> (b + 1)); m++) begin
                for (int o = -win; o <= win; o++) begin
                    if (mode == 0) c = (b == CODE_W - 1 && m == 0 && o == -win) ? -1 : -2;
                    else c = ((2 * m + 1) << b) + o;
                    if (mode == 0 && c == -1) begin
                        for (int k = 2; k <= N - 2 && stop == 0; k++) begin
                            exp_list[exp_len] = k; exp_len++;
                            inl = real'(tval[k] - tval[1]) / lsb - real'(k - 1);
                            if (inl < 0.0) inl = -inl;
                            if (inl > real'(cur_spec) / 16.0) begin
                                stop = 1; exp_pass = 0; exp_fc = k;
                            end
                        end
                    end else if (mode == 1 && stop == 0 && c >= 2 && c <= N - 2 && seen[c] == 0) begin
                        seen[c] = 1;
                        exp_list[exp_len] = c; exp_len++;
                        inl = real'(tval[c] - tval[1]) / lsb - real'(c - 1);
                        if (inl < 0.0) inl = -inl;
                        if (inl > real'(cur_spec) / 16.0) begin
                            stop = 1; exp_pass = 0; exp_fc = c;
                        end
                    end
                end
            end
        end
    endtask

    // Measurement engine model (R3)
    initial begin
        forever begin
            @(negedge clk);
            if (meas_req_o && rst_n) begin
                if (req_cnt < exp_len)
                    check((req_cnt < 2) ? "R2" : cur_tag, int'(meas_code_o), exp_list[req_cnt], "request code");
                else
                    check("R5", 1, 0, "request beyond expected list");
                repeat (mdelay) begin
                    @(negedge clk);
                    if (!meas_req_o) check("R3", 0, 1, "request dropped before ack");
                end
                meas_ack_i = 1'b1;
                meas_val_i = MEAS_W'(tval[meas_code_o]);
                req_cnt++;
                @(negedge clk);
                meas_ack_i = 1'b0;
            end
        end
    end

    task automatic run_case(input string tag, input int mode, input int win,
                            input int spec, input int dly, input int mid_start);
        int fc_hold;
        int cnt_hold;
        cur_tag = tag;
        mdelay  = dly;
        cur_spec = spec;
        build(mode, win);
        req_cnt = 0;
        @(negedge clk);
        mode_i  = mode[0];
        win_i   = WIN_W'(win);
        spec_i  = SPEC_W'(spec);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R1", int'(busy_o), 1, "busy after start");
        check("R11", int'({done_o, pass_o, fail_code_o}), 0, "result cleared by start");
        if (mid_start != 0) begin
            repeat (12) @(negedge clk);
            mode_i  = ~mode[0];
            spec_i  = '0;
            win_i   = '0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int t = 0; t < 5000 && !done_o; t++) @(negedge clk);
        check(tag, int'(done_o), 1, "done reached");
        check((exp_pass != 0) ? "R6" : "R5", int'(pass_o), exp_pass, "pass flag");
        check((exp_pass != 0) ? "R6" : "R5", int'(fail_code_o), exp_fc, "failing code");
        check(tag, req_cnt, exp_len, "request count");
        fc_hold  = int'(fail_code_o);
        cnt_hold = req_cnt;
        repeat (6) @(negedge clk);
        check("R11", int'(fail_code_o), fc_hold, "failing code held");
        check("R11", int'(done_o), 1, "done held");
        check("R5", req_cnt, cnt_hold, "no request after end");
        spec_i = SPEC_W'(16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int last_c;
        set_clean();
        exp_len = 0;
        req_cnt = 0;
        repeat (3) @(negedge clk);
        check("R11", int'({busy_o, done_o, pass_o, meas_req_o}), 0, "reset outputs");
        check("R11", int'(fail_code_o), 0, "reset failing code");
        rst_n = 1'b1;
        @(negedge clk);

        // R7 ascending sweep, clean converter
        set_clean(); run_case("R7", 0, 0, 16, 0, 0);
        // R4 just over the limit (17/16 LSB)
        set_clean(); tval[10] += 17; run_case("R4", 0, 0, 16, 1, 0);
        // R4 exactly at the limit passes
        set_clean(); tval[10] += 16; run_case("R4", 0, 0, 16, 0, 0);
        // R5 negative error, slow engine
        set_clean(); tval[20] -= 17; run_case("R5", 0, 0, 16, 3, 0);
        // R4 half-LSB limit
        set_clean(); tval[5] += 9; run_case("R4", 0, 0, 8, 0, 0);
        // R8 priority order, several windows
        set_clean(); run_case("R8", 1, 1, 16, 0, 0);
        set_clean(); run_case("R8", 1, 0, 16, 2, 0);
        // R9 wide window clipped, no repeats
        set_clean(); run_case("R9", 1, 7, 16, 0, 0);
        set_clean(); run_case("R9", 1, 2, 16, 1, 0);
        // R8 fail near the half-scale boundary
        set_clean(); tval[17] += 20; run_case("R8", 1, 1, 16, 0, 0);
        // R5 violation on the last listed code
        set_clean(); cur_spec = 16; build(1, 2); last_c = exp_list[exp_len-1];
        tval[last_c] += 17; run_case("R5", 1, 2, 16, 0, 0);
        // R10 zero span
        set_clean(); tval[N-1] = tval[1]; run_case("R10", 0, 0, 16, 0, 0);
        // R1 start while busy ignored, inputs changed mid-run
        set_clean(); run_case("R1", 0, 0, 16, 1, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule